// File: doc/BRIEF.md
# Priority-Resolving Interrupt Selector

This block is the arbitration core of an interrupt controller's normal-type path. It receives a vector of requests that have already been qualified (pending, enabled and of normal type), together with a 4-bit priority for every source, and picks a single winner. The winner is the request with the largest priority. When several requests share that priority, the highest-numbered source among them wins. The block also reports whether any request exists and packs the source and priority into one 32-bit word for the vector read path.

A second result compares the request set against a 5-bit threshold and drives the normal interrupt output. This flag is raised when some request's priority is strictly above the threshold. The all-ones threshold value is special: with it, the flag passes any request at all.

Both results are captured in registers on an input strobe. They appear one cycle later with a valid pulse, and they hold until the next strobe.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Among the requests set in `reqVec`, the selected source has the largest priority, and `winPrio` equals that source's own priority.
- R2: When several requests share the largest priority, the highest-numbered of them is selected.
- R3: The priority of source n is `prioFlat[32*(n/8) + 4*(n%8) + 3 : 32*(n/8) + 4*(n%8)]`. This is nibble (n mod 8) of 32-bit word (n/8).
- R4: With no request set, `anyReq` is 0, `winSrc` and `winPrio` are 0, and `packedResult` is 32'hFFFFFFFF.
- R5: With a request set, `anyReq` is 1. `packedResult[31:16]` holds the winning source number, zero-extended. `packedResult[15:4]` is zero. `packedResult[3:0]` holds the winning priority.
- R6: When `threshold` is not 5'h1F, `aboveThr` is 1 exactly when some request has a priority strictly greater than `threshold`. It follows that any threshold from 15 to 30 gives 0.
- R7: When `threshold` is 5'h1F, `aboveThr` equals `anyReq`. It is 1 for any request, including one whose priority is 0.
- R8: Inputs are sampled at a rising clock edge where `inStrobe` is 1. The results and a one-cycle `outValid` pulse appear after that edge. Strobes on consecutive cycles give consecutive results.
- R9: While `inStrobe` is 0, changes on `reqVec`, `prioFlat` and `threshold` have no effect on any output, and `outValid` stays 0.
- R10: After reset, `outValid`, `anyReq` and `aboveThr` are 0, `winSrc` and `winPrio` are 0, and `packedResult` is 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inStrobe | input | 1 | Sample the inputs at this edge |
| reqVec | input | 64 | Qualified request per source |
| prioFlat | input | 256 | Eight 32-bit words of 4-bit priorities |
| threshold | input | 5 | Mask level for the above-threshold flag |
| outValid | output | 1 | One-cycle pulse: new results are present |
| anyReq | output | 1 | At least one request was present |
| winSrc | output | 6 | Winning source number |
| winPrio | output | 4 | Winning priority |
| packedResult | output | 32 | Source in [31:16] and priority in [3:0], or all ones when empty |
| aboveThr | output | 1 | A request exceeds the threshold, or any request when the threshold is 5'h1F |

## Verification
The winner selection and the threshold comparison are captured at the same strobe edge from the same request set, so the two must agree in the same cycle. The bench builds request sets where the top priority sits just below, exactly at and just above the threshold. It also covers the all-pass value with a priority-0 request. In each case the source, the priority, the packed word and the flag are judged together against a model computed from the requirements. Back-to-back strobes and randomized sets provoke the same overlap with fresh data every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned DefNumSrc = 64;
  localparam int unsigned DefPrioW  = 4;
  localparam int unsigned DefThrW   = 5;
  localparam int unsigned DefWordW  = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } arb_strobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inStrobe,
  output arb_strobe_t strb,
  output logic        outValid
);
  always_comb strb.capture = inStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inStrobe;
  end
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = DefNumSrc,
  parameter int unsigned PRIO_W  = DefPrioW,
  parameter int unsigned THR_W   = DefThrW,
  parameter int unsigned WORD_W  = DefWordW,
  localparam int unsigned SRC_W     = $clog2(NUM_SRC),
  localparam int unsigned PER_WORD  = WORD_W / PRIO_W,
  localparam int unsigned NUM_WORDS = NUM_SRC / PER_WORD
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  arb_strobe_t                 strb,
  input  logic [NUM_SRC-1:0]          reqVec,
  input  logic [NUM_WORDS*WORD_W-1:0] prioFlat,
  input  logic [THR_W-1:0]            threshold,
  output logic                        anyReq,
  output logic [SRC_W-1:0]            winSrc,
  output logic [PRIO_W-1:0]           winPrio,
  output logic [WORD_W-1:0]           packedResult,
  output logic                        aboveThr
);
  localparam int unsigned NODES  = 2 * NUM_SRC - 1;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam logic [THR_W-1:0] ALL_PASS = {THR_W{1'b1}};

  typedef struct packed {
    logic              vld;
    logic [SRC_W-1:0]  idx;
    logic [PRIO_W-1:0] pri;
  } node_t;

  // tie rule: the higher-index side wins on equal priority
  function automatic node_t pickNode(node_t lo, node_t hi);
    if (hi.vld && (!lo.vld || hi.pri >= lo.pri)) return hi;
    return lo;
  endfunction

  logic [PRIO_W-1:0] leafPrio [NUM_SRC];
  logic [NUM_SRC-1:0] gtVec;
  node_t tree [NODES];
  node_t root;
  logic  aboveNext;

  // leaves, heap order: node k has children 2k+1 (lower) and 2k+2 (higher)
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
    localparam int unsigned WSEL = i / PER_WORD;
    localparam int unsigned NSEL = i % PER_WORD;
    assign leafPrio[i] = prioFlat[WSEL*WORD_W + NSEL*PRIO_W +: PRIO_W];
    assign tree[NUM_SRC-1+i] = '{vld: reqVec[i], idx: SRC_W'(i), pri: leafPrio[i]};
    assign gtVec[i] = reqVec[i] && (THR_W'(leafPrio[i]) > threshold);
  end

  for (genvar k = 0; k < NUM_SRC - 1; k++) begin : g_node
    assign tree[k] = pickNode(tree[2*k+1], tree[2*k+2]);
  end

  assign root      = tree[0];
  assign aboveNext = (threshold == ALL_PASS) ? (|reqVec) : (|gtVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anyReq       <= 1'b0;
      winSrc       <= '0;
      winPrio      <= '0;
      packedResult <= '1;
      aboveThr     <= 1'b0;
    end else if (strb.capture) begin
      anyReq   <= root.vld;
      aboveThr <= aboveNext;
      if (root.vld) begin
        winSrc       <= root.idx;
        winPrio      <= root.pri;
        packedResult <= {HALF_W'(root.idx), HALF_W'(root.pri)};
      end else begin
        winSrc       <= '0;
        winPrio      <= '0;
        packedResult <= '1;
      end
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = DefNumSrc,
  parameter int unsigned PRIO_W  = DefPrioW,
  parameter int unsigned THR_W   = DefThrW,
  parameter int unsigned WORD_W  = DefWordW,
  localparam int unsigned SRC_W     = $clog2(NUM_SRC),
  localparam int unsigned NUM_WORDS = NUM_SRC / (WORD_W / PRIO_W)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inStrobe,
  input  logic [NUM_SRC-1:0]          reqVec,
  input  logic [NUM_WORDS*WORD_W-1:0] prioFlat,
  input  logic [THR_W-1:0]            threshold,
  output logic                        outValid,
  output logic                        anyReq,
  output logic [SRC_W-1:0]            winSrc,
  output logic [PRIO_W-1:0]           winPrio,
  output logic [WORD_W-1:0]           packedResult,
  output logic                        aboveThr
);
  arb_strobe_t strb;

  arb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inStrobe (inStrobe),
    .strb     (strb),
    .outValid (outValid)
  );

  arb_datapath #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .THR_W   (THR_W),
    .WORD_W  (WORD_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqVec       (reqVec),
    .prioFlat     (prioFlat),
    .threshold    (threshold),
    .anyReq       (anyReq),
    .winSrc       (winSrc),
    .winPrio      (winPrio),
    .packedResult (packedResult),
    .aboveThr     (aboveThr)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned THR_W   = 5,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC),
  localparam int unsigned FLAT_W = NUM_SRC * PRIO_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              inStrobe,
  input logic [NUM_SRC-1:0] reqVec,
  input logic [FLAT_W-1:0] prioFlat,
  input logic [THR_W-1:0]  threshold,
  input logic              outValid,
  input logic              anyReq,
  input logic [SRC_W-1:0]  winSrc,
  input logic [PRIO_W-1:0] winPrio,
  input logic [WORD_W-1:0] packedResult,
  input logic              aboveThr
);
  localparam int unsigned HALF_W = WORD_W / 2;
  logic [NUM_SRC-1:0] reqD;
  logic [FLAT_W-1:0]  prioD;
  logic [THR_W-1:0]   thrD;
  int unsigned        shAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqD  <= '0;
      prioD <= '0;
      thrD  <= '0;
    end else if (inStrobe) begin
      reqD  <= reqVec;
      prioD <= prioFlat;
      thrD  <= threshold;
    end
  end

  assign shAmt = int'(winSrc) * PRIO_W;

  // R8
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inStrobe |=> outValid);
  // R9
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inStrobe |=> !outValid);
  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inStrobe |=> $stable(packedResult) && $stable(aboveThr) && $stable(anyReq));
  // R4
  a_r4_empty: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !anyReq) |-> (packedResult == {WORD_W{1'b1}} && reqD == '0));
  // R5
  a_r5_packed: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && anyReq) |-> (packedResult == {HALF_W'(winSrc), HALF_W'(winPrio)}));
  // R1
  a_r1_winner_real: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && anyReq) |-> (reqD[winSrc] && prioD[shAmt +: PRIO_W] == winPrio));
  // R6
  a_r6_threshold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && anyReq && thrD != {THR_W{1'b1}}) |-> (aboveThr == (THR_W'(winPrio) > thrD)));
  // R7
  a_r7_all_pass: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && thrD == {THR_W{1'b1}}) |-> (aboveThr == anyReq));
endmodule

bind irq_prio_arbiter arb_checker #(
  .NUM_SRC (NUM_SRC),
  .PRIO_W  (PRIO_W),
  .THR_W   (THR_W),
  .WORD_W  (WORD_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .inStrobe     (inStrobe),
  .reqVec       (reqVec),
  .prioFlat     (prioFlat),
  .threshold    (threshold),
  .outValid     (outValid),
  .anyReq       (anyReq),
  .winSrc       (winSrc),
  .winPrio      (winPrio),
  .packedResult (packedResult),
  .aboveThr     (aboveThr)
);

// File: tb/test_irq_prio_arbiter.sv
`timescale 1ns/1ps
module test_irq_prio_arbiter;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inStrobe = 1'b0;
  logic [63:0]  reqVec = '0;
  logic [255:0] prioFlat = '0;
  logic [4:0]   threshold = 5'h1F;
  logic         outValid, anyReq, aboveThr;
  logic [5:0]   winSrc;
  logic [3:0]   winPrio;
  logic [31:0]  packedResult;

  int checks = 0;
  int errors = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  // expected values of the last strobe
  logic        eAny, eAbove;
  logic [5:0]  eSrc;
  logic [3:0]  ePrio;
  logic [31:0] ePacked;

  always #10 clk = ~clk;

  irq_prio_arbiter i_irq_prio_arbiter (
    .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .reqVec(reqVec),
    .prioFlat(prioFlat), .threshold(threshold), .outValid(outValid),
    .anyReq(anyReq), .winSrc(winSrc), .winPrio(winPrio),
    .packedResult(packedResult), .aboveThr(aboveThr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R3 layout: word n/8, nibble n%8
  task automatic setPrio(input int n, input logic [3:0] p);
    prioFlat[32*(n/8) + 4*(n%8) +: 4] = p;
  endtask

  function automatic logic [3:0] getPrio(input int n);
    return prioFlat[32*(n/8) + 4*(n%8) +: 4];
  endfunction

  // model from R1, R2, R4..R7
  task automatic model();
    int best;
    best = -1;
    eAbove = 1'b0;
    for (int n = 0; n < 64; n++) begin
      if (reqVec[n]) begin
        if (best < 0 || getPrio(n) >= getPrio(best)) best = n;
        if ({1'b0, getPrio(n)} > threshold) eAbove = 1'b1;
      end
    end
    eAny = (best >= 0);
    if (threshold == 5'h1F) eAbove = eAny;
    if (eAny) begin
      eSrc = 6'(best);
      ePrio = getPrio(best);
      ePacked = {16'(eSrc), 16'(ePrio)};
    end else begin
      eSrc = '0;
      ePrio = '0;
      ePacked = 32'hFFFFFFFF;
    end
  endtask

  task automatic checkAll(input string tag, input logic expValid);
    chk({tag, " outValid R8"}, 32'(outValid), 32'(expValid));
    chk({tag, " anyReq R4"}, 32'(anyReq), 32'(eAny));
    chk({tag, " winSrc R1 R2"}, 32'(winSrc), 32'(eSrc));
    chk({tag, " winPrio R1"}, 32'(winPrio), 32'(ePrio));
    chk({tag, " packed R5"}, packedResult, ePacked);
    chk({tag, " aboveThr R6 R7"}, 32'(aboveThr), 32'(eAbove));
  endtask

  // strobe once with current inputs, sample after the capturing edge
  task automatic run(input string tag);
    @(negedge clk);
    inStrobe = 1'b1;
    model();
    @(negedge clk);
    inStrobe = 1'b0;
    checkAll(tag, 1'b1);
  endtask

  task automatic t_reset();
    chk("reset outValid R10", 32'(outValid), 0);
    chk("reset anyReq R10", 32'(anyReq), 0);
    chk("reset aboveThr R10", 32'(aboveThr), 0);
    chk("reset winSrc R10", 32'(winSrc), 0);
    chk("reset winPrio R10", 32'(winPrio), 0);
    chk("reset packed R10", packedResult, 32'hFFFFFFFF);
  endtask

  task automatic t_single();
    prioFlat = '0; setPrio(37, 4'd9);
    reqVec = 64'd1 << 37; threshold = 5'd0;
    run("single R1");
    chk("single src R1", 32'(winSrc), 37);
  endtask

  task automatic t_max();
    prioFlat = '0;
    setPrio(2, 4'd3); setPrio(18, 4'd12); setPrio(50, 4'd7); setPrio(63, 4'd11);
    reqVec = (64'd1 << 2) | (64'd1 << 18) | (64'd1 << 50) | (64'd1 << 63);
    threshold = 5'd4;
    run("max R1");
    chk("max src R1", 32'(winSrc), 18);
    reqVec[18] = 1'b0;
    run("max2 R1");
    chk("max2 src R1", 32'(winSrc), 63);
  endtask

  task automatic t_tie();
    prioFlat = '0;
    setPrio(3, 4'd8); setPrio(40, 4'd8); setPrio(63, 4'd8); setPrio(10, 4'd2);
    reqVec = (64'd1 << 3) | (64'd1 << 40) | (64'd1 << 63) | (64'd1 << 10);
    threshold = 5'd7;
    run("tie R2");
    chk("tie top R2", 32'(winSrc), 63);
    reqVec[63] = 1'b0;
    run("tie2 R2");
    chk("tie mid R2", 32'(winSrc), 40);
    prioFlat = '0; reqVec = 64'h0000_0000_0000_0011;
    run("tie zero R2");
    chk("tie zero prio R2", 32'(winSrc), 4);
  endtask

  task automatic t_map();
    // word 7 nibble 7 -> source 63, word 1 nibble 0 -> source 8
    prioFlat = '0;
    prioFlat[7*32 + 28 +: 4] = 4'd5;
    prioFlat[1*32 + 0 +: 4]  = 4'd6;
    prioFlat[0*32 + 28 +: 4] = 4'd4;
    reqVec = (64'd1 << 63) | (64'd1 << 8) | (64'd1 << 7);
    threshold = 5'd1;
    run("map R3");
    chk("map src R3", 32'(winSrc), 8);
    chk("map prio R3", 32'(winPrio), 6);
    reqVec[8] = 1'b0;
    run("map2 R3");
    chk("map2 prio R3", 32'(winPrio), 5);
  endtask

  task automatic t_empty();
    reqVec = '0; threshold = 5'd3;
    run("empty R4");
    chk("empty packed R4", packedResult, 32'hFFFFFFFF);
    threshold = 5'h1F;
    run("empty allpass R7");
  endtask

  task automatic t_threshold();
    prioFlat = '0; setPrio(10, 4'd6); setPrio(20, 4'd3);
    reqVec = (64'd1 << 10) | (64'd1 << 20);
    threshold = 5'd5;  run("thr below R6");  chk("thr5 flag R6", 32'(aboveThr), 1);
    threshold = 5'd6;  run("thr equal R6");  chk("thr6 flag R6", 32'(aboveThr), 0);
    threshold = 5'd2;  run("thr low R6");
    threshold = 5'd20; run("thr high R6");   chk("thr20 flag R6", 32'(aboveThr), 0);
    setPrio(10, 4'd15);
    threshold = 5'd30; run("thr30 R6");      chk("thr30 flag R6", 32'(aboveThr), 0);
    threshold = 5'd14; run("thr14 R6");      chk("thr14 flag R6", 32'(aboveThr), 1);
  endtask

  task automatic t_allpass();
    prioFlat = '0; reqVec = 64'd1 << 33;
    threshold = 5'd0;  run("prio0 R6");      chk("prio0 thr0 R6", 32'(aboveThr), 0);
    threshold = 5'h1F; run("allpass R7");    chk("allpass flag R7", 32'(aboveThr), 1);
  endtask

  task automatic t_hold();
    prioFlat = '0; setPrio(12, 4'd9); reqVec = 64'd1 << 12; threshold = 5'd4;
    run("hold base R9");
    reqVec = ~64'd0; prioFlat = ~256'd0; threshold = 5'd0;
    repeat (3) @(negedge clk);
    checkAll("hold R9", 1'b0);
  endtask

  task automatic t_backtoback();
    @(negedge clk);
    prioFlat = '0; setPrio(5, 4'd2); reqVec = 64'd1 << 5; threshold = 5'd1;
    inStrobe = 1'b1; model();
    @(negedge clk);
    checkAll("b2b first R8", 1'b1);
    setPrio(44, 4'd13); reqVec = (64'd1 << 44) | (64'd1 << 5); threshold = 5'd13;
    model();
    @(negedge clk);
    inStrobe = 1'b0;
    checkAll("b2b second R8", 1'b1);
    @(negedge clk);
    checkAll("b2b idle R8", 1'b0);
  endtask

  function automatic logic [63:0] nextRng(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    return y ^ (y << 17);
  endfunction

  task automatic t_random();
    for (int it = 0; it < 40; it++) begin
      logic [63:0] a;
      rng = nextRng(rng); a = rng;
      rng = nextRng(rng); reqVec = a & rng & ((it % 3 == 0) ? rng >> 5 : ~64'd0);
      for (int w = 0; w < 4; w++) begin
        rng = nextRng(rng);
        prioFlat[64*w +: 64] = rng;
      end
      rng = nextRng(rng);
      threshold = rng[4:0];
      run("random R1 R2 R6");
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_max();
    t_tie();
    t_map();
    t_empty();
    t_threshold();
    t_allpass();
    t_hold();
    t_backtoback();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule